// File: doc/BRIEF.md
# I2C Bus Error Monitor

This block sits beside an I2C controller and watches the two bus lines after bringing them into the local clock domain. From the sampled lines it finds START and STOP conditions, keeps a count of SCL rising edges since the last START, and marks where a byte is being shifted. It combines that view with status signals from the controller: master mode, a master-initiated STOP request, reception of a 10-bit read header, and completion of the 10-bit write first byte. From these it decides when the bus sequence is illegal.

On an illegal sequence it sets a sticky error flag. In the same step it drops the interface enable, clears the auxiliary control bits, and sends a one-cycle clear pulse to the controller's status logic. It raises an interrupt if the error interrupt enable is set. Software reaches the flag, its enable, the auxiliary bits and the interface enable through one 8-bit register. The layout is: bit 7 error flag, bit 6 error interrupt enable, bits 5..1 auxiliary control, bit 0 interface enable. When the interface is switched on while a transfer is already running, checking waits for the next STOP.

Top module: `i2c_buserr_monitor`

## Requirements
- R1: After reset the register reads 0x00, and `irq`, `if_enable`, `ctl_aux` and `status_clr` are all 0.
- R2: A START or STOP seen while a transfer is open and the rising-edge count since START is 2 to 9 sets the error flag (bit 7).
- R3: A START or STOP at count 0 or 1 (right after START, or on the first clock after the acknowledge) is legal and leaves the flag clear.
- R4: A 10-bit read header pulse (`hdr10_rd_rx`) while `tenbit_wr_done` is 0 sets the flag. With `tenbit_wr_done` at 1 the pulse has no effect.
- R5: In master mode, a STOP during an open transfer without `master_stop_req` sets the flag. With the request present it does not.
- R6: An error clears bit 0 and bits 5..1, keeps bit 6, and pulses `status_clr` for exactly one cycle.
- R7: The flag is sticky. Writing 0 to bit 7 clears it, and writing 1 to bit 7 leaves it unchanged.
- R8: With `reg_rd_rmw` high, bit 7 of `reg_rdata` reads 1 whatever the flag holds. Otherwise it shows the flag.
- R9: `irq` is high exactly while the flag and bit 6 are both 1, and it stays high until software clears the flag.
- R10: If bit 0 goes from 0 to 1 while a transfer is open, no error is raised until a STOP has been seen. Detection works again after that STOP.
- R11: Bits 5..1 read 0 whenever bit 0 is 0, including when they are written together with bit 0 = 0.
- R12: A write that sets bit 0 is ignored for bit 0 if the flag stays set after that write (bit 7 written as 1).
- R13: An error in the same cycle as a flag-clearing write leaves the flag set and the interface disabled.
- R14: No error is raised while bit 0 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_in | input | 1 | Raw SCL line |
| sda_in | input | 1 | Raw SDA line |
| master_mode | input | 1 | Controller is operating as master |
| master_stop_req | input | 1 | Controller is issuing the STOP itself |
| hdr10_rd_rx | input | 1 | One-cycle pulse: a 10-bit read header was received |
| tenbit_wr_done | input | 1 | The 10-bit write first byte has completed |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rd_rmw | input | 1 | The current read belongs to a read-modify-write |
| reg_rdata | output | 8 | Register read data |
| irq | output | 1 | Error interrupt |
| if_enable | output | 1 | Interface enable to the controller |
| ctl_aux | output | 5 | Auxiliary control bits to the controller |
| status_clr | output | 1 | One-cycle clear pulse for controller status |

## Verification
The two functions that can meet in one cycle are the error setter and the software write that clears the flag and re-enables the interface. The bench provokes this by raising `hdr10_rd_rx` with `tenbit_wr_done` low on the same clock as a write of 0x41. The result is judged at the ports: the register must read 0xC0, the interrupt must be high, and one more `status_clr` pulse must have been seen. A weaker form of the same overlap occurs when the enable is written while a transfer is open. In that case the next illegal START and STOP must stay silent until the STOP has passed.

// File: rtl/i2cbm_pkg.sv
package i2cbm_pkg;

  localparam int AUX_W    = 5;
  localparam int REG_W    = AUX_W + 3;
  localparam int FLAG_POS = REG_W - 1;
  localparam int IE_POS   = REG_W - 2;

  // Register image, most significant field first.
  typedef struct packed {
    logic             flag;
    logic             ie;
    logic [AUX_W-1:0] aux;
    logic             en;
  } ctl_reg_t;

endpackage

// File: rtl/i2cbm_rst_sync.sv
module i2cbm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/i2cbm_line_sync.sv
module i2cbm_line_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_line
    logic [STAGES-1:0] chain_q;

    // Idle bus level is high, so the chain resets to ones.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '1;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], d[i]};
      end
    end

    assign q[i] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/i2cbm_bus_tracker.sv
module i2cbm_bus_tracker #(
  parameter int BYTE_BITS = 9,
  parameter int LEGAL_POS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_c,
  output logic stop_c,
  output logic in_xfer,
  output logic shift_win
);

  localparam int CNT_W = $clog2(BYTE_BITS + 1);

  logic             scl_p_q, sda_p_q;
  logic             scl_rise;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             xfer_q, xfer_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p_q <= 1'b1;
      sda_p_q <= 1'b1;
    end else begin
      scl_p_q <= scl_s;
      sda_p_q <= sda_s;
    end
  end

  // Conditions are SDA edges with SCL high on both samples.
  assign start_c  = scl_s & scl_p_q & sda_p_q & ~sda_s;
  assign stop_c   = scl_s & scl_p_q & ~sda_p_q & sda_s;
  assign scl_rise = scl_s & ~scl_p_q;

  always_comb begin
    cnt_d  = cnt_q;
    xfer_d = xfer_q;
    if (start_c) begin
      cnt_d  = '0;
      xfer_d = 1'b1;
    end else if (stop_c) begin
      cnt_d  = '0;
      xfer_d = 1'b0;
    end else if (scl_rise && xfer_q) begin
      if (cnt_q == CNT_W'(BYTE_BITS)) begin
        cnt_d = CNT_W'(1);
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      xfer_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      xfer_q <= xfer_d;
    end
  end

  assign in_xfer   = xfer_q;
  assign shift_win = xfer_q & (cnt_q > CNT_W'(LEGAL_POS));

endmodule

// File: rtl/i2cbm_err_detect.sv
module i2cbm_err_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic en_q,
  input  logic en_rise,
  input  logic in_xfer,
  input  logic start_c,
  input  logic stop_c,
  input  logic shift_win,
  input  logic master_mode,
  input  logic master_stop_req,
  input  logic hdr10_rd_rx,
  input  logic tenbit_wr_done,
  output logic err_hit,
  output logic suppress
);

  logic sup_q, sup_d;
  logic active;
  logic cond_misplaced, cond_master_stop, cond_hdr10;

  assign active           = en_q & ~sup_q;
  assign cond_misplaced   = (start_c | stop_c) & shift_win;
  assign cond_master_stop = stop_c & in_xfer & master_mode & ~master_stop_req;
  assign cond_hdr10       = hdr10_rd_rx & ~tenbit_wr_done;
  assign err_hit          = active & (cond_misplaced | cond_master_stop | cond_hdr10);

  // Enabling in the middle of a transfer holds detection off until a STOP.
  always_comb begin
    sup_d = sup_q;
    if (stop_c) begin
      sup_d = 1'b0;
    end else if (en_rise && in_xfer && !err_hit) begin
      sup_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sup_q <= 1'b0;
    end else begin
      sup_q <= sup_d;
    end
  end

  assign suppress = sup_q;

endmodule

// File: rtl/i2c_buserr_monitor.sv
module i2c_buserr_monitor
  import i2cbm_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_BITS   = 9,
  parameter int LEGAL_POS   = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic             master_mode,
  input  logic             master_stop_req,
  input  logic             hdr10_rd_rx,
  input  logic             tenbit_wr_done,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             reg_rd_rmw,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq,
  output logic             if_enable,
  output logic [AUX_W-1:0] ctl_aux,
  output logic             status_clr
);

  logic       rst_n_i;
  logic [1:0] lines_s;
  logic       start_c, stop_c, in_xfer, shift_win;
  logic       err_hit, suppress;
  ctl_reg_t   ctl_q, ctl_d, wr_view;
  logic       wr_clear, flag_hold, en_req, en_rise;
  logic       clr_q, clr_d;

  i2cbm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_n_i)
  );

  i2cbm_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_i),
    .d     ({scl_in, sda_in}),
    .q     (lines_s)
  );

  i2cbm_bus_tracker #(.BYTE_BITS(BYTE_BITS), .LEGAL_POS(LEGAL_POS)) u_trk (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .scl_s     (lines_s[1]),
    .sda_s     (lines_s[0]),
    .start_c   (start_c),
    .stop_c    (stop_c),
    .in_xfer   (in_xfer),
    .shift_win (shift_win)
  );

  i2cbm_err_detect u_det (
    .clk             (clk),
    .rst_n           (rst_n_i),
    .en_q            (ctl_q.en),
    .en_rise         (en_rise),
    .in_xfer         (in_xfer),
    .start_c         (start_c),
    .stop_c          (stop_c),
    .shift_win       (shift_win),
    .master_mode     (master_mode),
    .master_stop_req (master_stop_req),
    .hdr10_rd_rx     (hdr10_rd_rx),
    .tenbit_wr_done  (tenbit_wr_done),
    .err_hit         (err_hit),
    .suppress        (suppress)
  );

  assign wr_view   = ctl_reg_t'(reg_wdata);
  assign wr_clear  = reg_wr & ~wr_view.flag;
  assign flag_hold = ctl_q.flag & ~wr_clear;
  // Software may only turn the interface on once the flag is gone.
  assign en_req    = reg_wr ? (wr_view.en & ~flag_hold) : ctl_q.en;
  assign en_rise   = en_req & ~ctl_q.en;

  always_comb begin
    ctl_d      = ctl_q;
    ctl_d.flag = flag_hold;
    ctl_d.en   = en_req;
    if (reg_wr) begin
      ctl_d.ie  = wr_view.ie;
      ctl_d.aux = wr_view.aux;
    end
    if (err_hit) begin
      ctl_d.flag = 1'b1;
      ctl_d.en   = 1'b0;
    end
    if (!ctl_d.en) begin
      ctl_d.aux = '0;
    end
    clr_d = err_hit;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      ctl_q <= '0;
      clr_q <= 1'b0;
    end else begin
      ctl_q <= ctl_d;
      clr_q <= clr_d;
    end
  end

  assign reg_rdata  = {ctl_q.flag | reg_rd_rmw, ctl_q.ie, ctl_q.aux, ctl_q.en};
  assign irq        = ctl_q.flag & ctl_q.ie;
  assign if_enable  = ctl_q.en;
  assign ctl_aux    = ctl_q.aux;
  assign status_clr = clr_q;

endmodule

// File: rtl/i2cbm_checks.sv
module i2cbm_checks
  import i2cbm_pkg::*;
(
  input logic             clk,
  input logic             rst_n_i,
  input logic             err_hit,
  input logic             suppress,
  input logic             flag,
  input logic             reg_wr,
  input logic [REG_W-1:0] reg_wdata,
  input logic             irq,
  input logic             if_enable,
  input logic [AUX_W-1:0] ctl_aux,
  input logic             status_clr
);

  p_err_sets_flag_r2: assert property (@(posedge clk) disable iff (!rst_n_i)
    err_hit |=> flag);

  p_err_halts_r6: assert property (@(posedge clk) disable iff (!rst_n_i)
    err_hit |=> (!if_enable && ctl_aux == '0 && status_clr));

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n_i)
    (flag && !(reg_wr && !reg_wdata[FLAG_POS])) |=> flag);

  p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n_i)
    (irq && !reg_wr) |=> irq);

  p_quiet_suppressed_r10: assert property (@(posedge clk) disable iff (!rst_n_i)
    suppress |-> !err_hit);

  p_aux_off_r11: assert property (@(posedge clk) disable iff (!rst_n_i)
    !if_enable |-> ctl_aux == '0);

  p_enable_blocked_r12: assert property (@(posedge clk) disable iff (!rst_n_i)
    $rose(if_enable) |-> !flag);

  p_collide_r13: assert property (@(posedge clk) disable iff (!rst_n_i)
    (err_hit && reg_wr) |=> (flag && !if_enable));

  p_disabled_r14: assert property (@(posedge clk) disable iff (!rst_n_i)
    !if_enable |-> !err_hit);

endmodule

bind i2c_buserr_monitor i2cbm_checks u_checks (
  .clk        (clk),
  .rst_n_i    (rst_n_i),
  .err_hit    (err_hit),
  .suppress   (suppress),
  .flag       (ctl_q.flag),
  .reg_wr     (reg_wr),
  .reg_wdata  (reg_wdata),
  .irq        (irq),
  .if_enable  (if_enable),
  .ctl_aux    (ctl_aux),
  .status_clr (status_clr)
);

// File: tb/i2c_buserr_monitor_test.sv
module i2c_buserr_monitor_test;
  import i2cbm_pkg::*;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst_n = 1'b0;
  logic             scl_in = 1'b1, sda_in = 1'b1;
  logic             master_mode = 1'b0, master_stop_req = 1'b0;
  logic             hdr10_rd_rx = 1'b0, tenbit_wr_done = 1'b0;
  logic             reg_wr = 1'b0, reg_rd_rmw = 1'b0;
  logic [REG_W-1:0] reg_wdata = '0;
  logic [REG_W-1:0] reg_rdata;
  logic             irq, if_enable, status_clr;
  logic [AUX_W-1:0] ctl_aux;

  i2c_buserr_monitor uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .master_mode(master_mode), .master_stop_req(master_stop_req),
    .hdr10_rd_rx(hdr10_rd_rx), .tenbit_wr_done(tenbit_wr_done),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd_rmw(reg_rd_rmw),
    .reg_rdata(reg_rdata), .irq(irq), .if_enable(if_enable),
    .ctl_aux(ctl_aux), .status_clr(status_clr)
  );

  typedef struct {
    int         req;
    logic [7:0] rdata;
    logic       irq;
    logic       rmw;
    int         clr;
  } exp_t;

  exp_t sb_q[$];
  int   checks = 0;
  int   errors = 0;
  int   clr_seen = 0;
  int   exp_clr = 0;
  bit   done = 1'b0;

  always @(posedge clk) if (status_clr) clr_seen++;

  // Monitor: pops each expected item and compares against the ports.
  initial begin
    forever begin
      exp_t it;
      @(negedge clk);
      if (sb_q.size() > 0) begin
        it = sb_q[0];
        reg_rd_rmw = it.rmw;
        #1;
        checks++;
        if (reg_rdata !== it.rdata || irq !== it.irq || clr_seen != it.clr ||
            (!it.rmw && (if_enable !== it.rdata[0] || ctl_aux !== it.rdata[5:1]))) begin
          errors++;
          $display("FAIL R%0d: rdata=%h irq=%b en=%b aux=%h clr=%0d, expected rdata=%h irq=%b clr=%0d",
                   it.req, reg_rdata, irq, if_enable, ctl_aux, clr_seen,
                   it.rdata, it.irq, it.clr);
        end
        reg_rd_rmw = 1'b0;
        void'(sb_q.pop_front());
      end
    end
  end

  task automatic expect_state(input int req, input logic [7:0] rd, input logic ir,
                              input logic rmw);
    exp_t it;
    it.req = req; it.rdata = rd; it.irq = ir; it.rmw = rmw; it.clr = exp_clr;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
    @(negedge clk);
  endtask

  task automatic set_scl(input logic v);
    scl_in = v;
    repeat (6) @(negedge clk);
  endtask

  task automatic set_sda(input logic v);
    sda_in = v;
    repeat (6) @(negedge clk);
  endtask

  task automatic bus_start();
    set_sda(1'b1); set_scl(1'b1); set_sda(1'b0); set_scl(1'b0);
  endtask

  task automatic bus_bits(input int n);
    for (int i = 0; i < n; i++) begin
      set_sda(i[0]); set_scl(1'b1); set_scl(1'b0);
    end
  endtask

  task automatic bus_stop();
    set_sda(1'b0); set_scl(1'b1); set_sda(1'b1);
  endtask

  task automatic reg_write(input logic [7:0] v);
    reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic hdr_pulse(input logic wr_done, input logic with_wr, input logic [7:0] v);
    tenbit_wr_done = wr_done;
    hdr10_rd_rx = 1'b1;
    reg_wr = with_wr; reg_wdata = v;
    @(negedge clk);
    hdr10_rd_rx = 1'b0; reg_wr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    expect_state(1, 8'h00, 1'b0, 1'b0);                 // R1 reset state

    bus_start(); bus_bits(3); bus_stop();
    expect_state(14, 8'h00, 1'b0, 1'b0);                // R14 disabled: misplaced STOP ignored

    reg_write(8'h7F);
    expect_state(11, 8'h7F, 1'b0, 1'b0);                // R11 aux kept while enabled

    bus_start(); bus_stop();
    expect_state(3, 8'h7F, 1'b0, 1'b0);                 // R3 STOP right after START
    bus_start(); bus_bits(9); bus_start(); bus_bits(9); bus_stop();
    expect_state(3, 8'h7F, 1'b0, 1'b0);                 // R3 repeated START and STOP after ack

    bus_start(); bus_bits(4); bus_stop();
    exp_clr = 1;
    expect_state(2, 8'hC0, 1'b1, 1'b0);                 // R2 R6 R9 misplaced STOP

    reg_write(8'hC1);
    expect_state(12, 8'hC0, 1'b1, 1'b0);                // R12 R7 enable blocked, flag kept
    reg_write(8'h40);
    expect_state(7, 8'h40, 1'b0, 1'b0);                 // R7 R9 cleared by writing 0
    expect_state(8, 8'hC0, 1'b0, 1'b1);                 // R8 read-modify-write sees 1

    reg_write(8'h3E);
    expect_state(11, 8'h00, 1'b0, 1'b0);                // R11 aux forced 0 with enable 0

    reg_write(8'h41);
    hdr_pulse(1'b0, 1'b0, 8'h00);
    exp_clr = 2;
    expect_state(4, 8'hC0, 1'b1, 1'b0);                 // R4 header before write done
    reg_write(8'h41);
    hdr_pulse(1'b1, 1'b0, 8'h00);
    expect_state(4, 8'h41, 1'b0, 1'b0);                 // R4 header after write done

    master_mode = 1'b1;
    bus_start(); bus_stop();
    exp_clr = 3;
    expect_state(5, 8'hC0, 1'b1, 1'b0);                 // R5 unrequested STOP as master
    reg_write(8'h41);
    master_stop_req = 1'b1;
    bus_start(); bus_stop();
    expect_state(5, 8'h41, 1'b0, 1'b0);                 // R5 requested STOP
    master_mode = 1'b0; master_stop_req = 1'b0;

    reg_write(8'h40);
    bus_start(); bus_bits(3);
    reg_write(8'h41);
    expect_state(10, 8'h41, 1'b0, 1'b0);                // R10 enabled mid-transfer
    bus_start(); bus_bits(2); bus_stop();
    expect_state(10, 8'h41, 1'b0, 1'b0);                // R10 misplaced conditions suppressed
    bus_start(); bus_bits(3); bus_stop();
    exp_clr = 4;
    expect_state(10, 8'hC0, 1'b1, 1'b0);                // R10 detection back after STOP

    reg_write(8'h41);
    expect_state(7, 8'h41, 1'b0, 1'b0);                 // R7 cleared and re-enabled
    hdr_pulse(1'b0, 1'b1, 8'h41);
    exp_clr = 5;
    expect_state(13, 8'hC0, 1'b1, 1'b0);                // R13 error beats clearing write

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule